// File: doc/BRIEF.md
# Flag-Producing Increment, Add and Rotate ALU

This block is the arithmetic slice that handles the short counting and rotating operations of a small 8-bit processor core. It takes a byte operand, two 16-bit word operands and an operation code. From these it produces a result and a cycle count combinationally. It keeps the four condition flags (zero, subtract, half-carry, carry) in a register that it updates on the clock edge of each valid operation.

Each operation updates its own subset of the flags and leaves the others as they were. Byte increment and decrement take the half-carry from bit 3. The 16-bit add takes it from the nibble at bits 11..8 of its operands. Byte increment and decrement keep the carry flag, and the 16-bit add keeps the zero flag. The rotates are circular and always clear zero. Word increment and decrement touch no flag.

The cycle count reports what the surrounding sequencer must spend on the operation. A byte increment or decrement costs more when the operand is the byte in memory at the address held in the HL pair. Memory access and register writeback stay outside the block.

Top module: `flag_alu`

## Requirements
- R1: With op_code 0 (byte increment), res_o[7:0] equals byte_in+1 modulo 256 and res_o[15:8] is 0. After the clock edge, Z is set when that result is 0, N is cleared, H is set when byte_in[3:0] is 4'hF, and C keeps its previous value.
- R2: With op_code 1 (byte decrement), res_o[7:0] equals byte_in-1 modulo 256 and res_o[15:8] is 0. After the edge, Z is set when that result is 0, N is set, H is set when byte_in[3:0] is 0, and C keeps its previous value.
- R3: With op_code 2 (16-bit add), res_o equals word_a+word_b modulo 65536. After the edge, C is the carry out of bit 15, H is the carry out of word_a[11:8]+word_b[11:8] (no carry in from bit 7), N is cleared, and Z keeps its previous value.
- R4: op_code 3 rotates byte_in left circularly and op_code 4 rotates it right circularly. The result goes to res_o[7:0] with res_o[15:8] at 0. After the edge, C holds the bit that left the byte (bit 7 for left, bit 0 for right), and Z, N and H are all cleared whatever the result is.
- R5: op_code 5 gives word_b+1 and op_code 6 gives word_b-1, both modulo 65536 on res_o. Neither changes any flag.
- R6: cycles_o is 4 for byte increment and decrement with via_hl low and 12 with via_hl high. It is 8 for the 16-bit add and for word increment and decrement, and 4 for rotates and for op_code 7.
- R7: flags_o packs Z at bit 7, N at bit 6, H at bit 5 and C at bit 4, with bits 3..0 always 0. A clock edge with rst_n low sets flags_o to 8'h00.
- R8: flags_o keeps its value across an edge where op_vld is low or op_code is 7. op_code 7 drives res_o to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the flag register |
| op_vld | input | 1 | Operation valid; the flags update only when high |
| op_code | input | 3 | Operation select (0 inc8, 1 dec8, 2 add16, 3 rotl, 4 rotr, 5 inc16, 6 dec16, 7 none) |
| via_hl | input | 1 | Byte operand comes from memory at the HL address (cost only) |
| byte_in | input | 8 | Byte operand for increment, decrement and rotates |
| word_a | input | 16 | HL value for the 16-bit add |
| word_b | input | 16 | Register pair added to HL, or incremented or decremented |
| res_o | output | 16 | Combinational result, byte results zero-extended |
| flags_o | output | 8 | Registered flags Z,N,H,C at bits 7..4 |
| cycles_o | output | 5 | Combinational cycle cost of the selected operation |

## Verification
The assertions check on every cycle which flags each operation may change. Word operations, idle cycles and op_code 7 keep every flag. Byte increment keeps C and the 16-bit add keeps Z. A rotate leaves Z, N and H cleared with C equal to the bit that left the byte. The cycle count is always one of the three legal costs. The actual arithmetic values are shown only by the bench's scenarios, which compare results and flags against an independent model. These scenarios cover wrap at 8'hFF and 16'hFFFF, decrement from 0, nibble boundaries, and the case where the 16-bit half-carry ignores a carry coming out of the low byte.

// File: rtl/flag_alu_pkg.sv
// Shared types for the flag ALU: operation codes and the flag nibble.
package flag_alu_pkg;
    typedef enum logic [2:0] {
        OP_INC8  = 3'd0,
        OP_DEC8  = 3'd1,
        OP_ADD16 = 3'd2,
        OP_ROTL  = 3'd3,
        OP_ROTR  = 3'd4,
        OP_INC16 = 3'd5,
        OP_DEC16 = 3'd6,
        OP_NONE  = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flag_t;
endpackage

// File: rtl/flag_alu_step8.sv
// Byte increment/decrement unit.
// Produces the stepped byte and its flags; carry passes through unchanged.
// Assumes DATA_W >= 4 so that a low nibble exists.
module flag_alu_step8 #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0]  opnd,
    input  logic               dec,
    input  logic               cur_c,
    output logic [DATA_W-1:0]  res,
    output flag_alu_pkg::flag_t flg
);
    localparam int NIB = 4;

    // Step the operand and derive zero, subtract, half-carry/borrow flags.
    always_comb begin
        if (dec) begin
            res   = opnd - DATA_W'(1);
            flg.h = ~|opnd[NIB-1:0];
        end else begin
            res   = opnd + DATA_W'(1);
            flg.h = &opnd[NIB-1:0];
        end
        flg.z = (res == '0);
        flg.n = dec;
        flg.c = cur_c;
    end
endmodule

// File: rtl/flag_alu_add16.sv
// Word adder for the pair-into-HL add.
// Half-carry is the carry out of the nibble at bits HB+3..HB of the two operands,
// taken without the carry in from the low byte. Zero passes through unchanged.
module flag_alu_add16 #(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0]  lhs,
    input  logic [WORD_W-1:0]  rhs,
    input  logic               cur_z,
    output logic [WORD_W-1:0]  sum,
    output flag_alu_pkg::flag_t flg
);
    localparam int HB  = WORD_W / 2;
    localparam int NIB = 4;

    logic [WORD_W:0] full;
    logic [NIB:0]    nib_sum;

    // Full-width sum with carry out, plus the separate high-nibble sum.
    always_comb begin
        full    = {1'b0, lhs} + {1'b0, rhs};
        nib_sum = {1'b0, lhs[HB+NIB-1:HB]} + {1'b0, rhs[HB+NIB-1:HB]};
        sum     = full[WORD_W-1:0];
        flg.z   = cur_z;
        flg.n   = 1'b0;
        flg.h   = nib_sum[NIB];
        flg.c   = full[WORD_W];
    end
endmodule

// File: rtl/flag_alu_rot8.sv
// Circular byte rotate, direction fixed by ROT_LEFT.
// The bit that leaves one end re-enters at the other and is copied to carry.
module flag_alu_rot8 #(
    parameter int DATA_W   = 8,
    parameter bit ROT_LEFT = 1'b1
) (
    input  logic [DATA_W-1:0]  opnd,
    output logic [DATA_W-1:0]  res,
    output flag_alu_pkg::flag_t flg
);
    logic out_bit;

    generate
        if (ROT_LEFT) begin : g_left
            // Rotate toward the most significant end.
            always_comb begin
                out_bit = opnd[DATA_W-1];
                res     = {opnd[DATA_W-2:0], out_bit};
            end
        end else begin : g_right
            // Rotate toward the least significant end.
            always_comb begin
                out_bit = opnd[0];
                res     = {out_bit, opnd[DATA_W-1:1]};
            end
        end
    endgenerate

    // Rotates clear zero, subtract and half-carry.
    always_comb begin
        flg.z = 1'b0;
        flg.n = 1'b0;
        flg.h = 1'b0;
        flg.c = out_bit;
    end
endmodule

// File: rtl/flag_alu_cost.sv
// Cycle cost of each operation; memory operands cost more for byte steps.
module flag_alu_cost #(
    parameter int CYC_W    = 5,
    parameter int CYC_REG  = 4,
    parameter int CYC_WORD = 8,
    parameter int CYC_MEM  = 12
) (
    input  flag_alu_pkg::alu_op_e op,
    input  logic                  via_hl,
    output logic [CYC_W-1:0]      cycles
);
    import flag_alu_pkg::*;

    // Select the cost for the operation class.
    always_comb begin
        unique case (op)
            OP_INC8, OP_DEC8:            cycles = via_hl ? CYC_W'(CYC_MEM) : CYC_W'(CYC_REG);
            OP_ADD16, OP_INC16, OP_DEC16: cycles = CYC_W'(CYC_WORD);
            default:                     cycles = CYC_W'(CYC_REG);
        endcase
    end

    // R6
    always_comb begin
        legal_cost_chk: assert (cycles == CYC_W'(CYC_REG) || cycles == CYC_W'(CYC_WORD)
                                || cycles == CYC_W'(CYC_MEM) || $isunknown(op));
    end
endmodule

// File: rtl/flag_alu.sv
// Flag-producing ALU slice: byte step, word add, circular rotates, word step.
// Result and cycle cost are combinational; flags are registered and updated
// on each clock edge with op_vld high. Assumes DATA_W = WORD_W/2 and DATA_W >= 8.
module flag_alu #(
    parameter int DATA_W   = 8,
    parameter int WORD_W   = 16,
    parameter int CYC_W    = 5,
    parameter int CYC_REG  = 4,
    parameter int CYC_WORD = 8,
    parameter int CYC_MEM  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_vld,
    input  logic [2:0]        op_code,
    input  logic              via_hl,
    input  logic [DATA_W-1:0] byte_in,
    input  logic [WORD_W-1:0] word_a,
    input  logic [WORD_W-1:0] word_b,
    output logic [WORD_W-1:0] res_o,
    output logic [7:0]        flags_o,
    output logic [CYC_W-1:0]  cycles_o
);
    import flag_alu_pkg::*;

    localparam int PAD_W = WORD_W - DATA_W;

    alu_op_e op;
    flag_t   flg_q, flg_d;
    flag_t   step_f, add_f, rl_f, rr_f;
    logic [DATA_W-1:0] step_r, rl_r, rr_r;
    logic [WORD_W-1:0] add_r;

    assign op = alu_op_e'(op_code);

    flag_alu_step8 #(.DATA_W(DATA_W)) u_step (
        .opnd(byte_in), .dec(op == OP_DEC8), .cur_c(flg_q.c),
        .res(step_r), .flg(step_f)
    );

    flag_alu_add16 #(.WORD_W(WORD_W)) u_add (
        .lhs(word_a), .rhs(word_b), .cur_z(flg_q.z),
        .sum(add_r), .flg(add_f)
    );

    flag_alu_rot8 #(.DATA_W(DATA_W), .ROT_LEFT(1'b1)) u_rotl (
        .opnd(byte_in), .res(rl_r), .flg(rl_f)
    );

    flag_alu_rot8 #(.DATA_W(DATA_W), .ROT_LEFT(1'b0)) u_rotr (
        .opnd(byte_in), .res(rr_r), .flg(rr_f)
    );

    flag_alu_cost #(
        .CYC_W(CYC_W), .CYC_REG(CYC_REG), .CYC_WORD(CYC_WORD), .CYC_MEM(CYC_MEM)
    ) u_cost (
        .op(op), .via_hl(via_hl), .cycles(cycles_o)
    );

    // Select result and next flags for the requested operation.
    always_comb begin
        res_o = '0;
        flg_d = flg_q;
        unique case (op)
            OP_INC8, OP_DEC8: begin
                res_o = {{PAD_W{1'b0}}, step_r};
                flg_d = step_f;
            end
            OP_ADD16: begin
                res_o = add_r;
                flg_d = add_f;
            end
            OP_ROTL: begin
                res_o = {{PAD_W{1'b0}}, rl_r};
                flg_d = rl_f;
            end
            OP_ROTR: begin
                res_o = {{PAD_W{1'b0}}, rr_r};
                flg_d = rr_f;
            end
            OP_INC16: res_o = word_b + WORD_W'(1);
            OP_DEC16: res_o = word_b - WORD_W'(1);
            default:  res_o = '0;
        endcase
    end

    // Flag register: synchronous reset, update only on a valid operation.
    always_ff @(posedge clk) begin
        if (!rst_n)      flg_q <= '0;
        else if (op_vld) flg_q <= flg_d;
    end

    assign flags_o = {flg_q, 4'b0000};

    // R5
    word_step_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_vld && (op == OP_INC16 || op == OP_DEC16) |=> $stable(flags_o));

    // R8
    idle_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_vld || op == OP_NONE) |=> $stable(flags_o));

    // R1
    inc8_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_vld && op == OP_INC8 |=> flags_o[4] == $past(flags_o[4]) && !flags_o[6]);

    // R3
    add16_keeps_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_vld && op == OP_ADD16 |=> flags_o[7] == $past(flags_o[7]) && !flags_o[6]);

    // R4
    rotl_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_vld && op == OP_ROTL |=> flags_o[7:5] == 3'b000
                                  && flags_o[4] == $past(byte_in[DATA_W-1]));

    // R4
    rotr_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_vld && op == OP_ROTR |=> flags_o[7:5] == 3'b000 && flags_o[4] == $past(byte_in[0]));
endmodule

// File: tb/flag_alu_tb.sv
// Scoreboard bench: the driver computes expected items into a queue,
// the monitor pops one per clock edge and compares against the outputs.
module flag_alu_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_vld = 1'b0;
    logic [2:0]  op_code = 3'd7;
    logic        via_hl = 1'b0;
    logic [7:0]  byte_in = '0;
    logic [15:0] word_a = '0;
    logic [15:0] word_b = '0;
    logic [15:0] res_o;
    logic [7:0]  flags_o;
    logic [4:0]  cycles_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] q_res[$];
    logic [7:0]  q_flg[$];
    logic [4:0]  q_cyc[$];
    bit          q_chk[$];
    string       q_tag[$];

    logic [3:0] mdl_f = 4'h0;   // Z N H C

    always #(CLK_PERIOD/2) clk = ~clk;

    flag_alu u_dut (
        .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .op_code(op_code),
        .via_hl(via_hl), .byte_in(byte_in), .word_a(word_a), .word_b(word_b),
        .res_o(res_o), .flags_o(flags_o), .cycles_o(cycles_o)
    );

    // Independent reference model of the requirements.
    function automatic void model(input logic [2:0] op, input logic hl, input logic [7:0] b,
                                  input logic [15:0] wa, input logic [15:0] wb,
                                  input logic [3:0] fin, output logic [15:0] r,
                                  output logic [3:0] fo, output logic [4:0] cy);
        logic [16:0] s;
        logic [4:0]  hn;
        fo = fin; r = 16'h0; cy = 5'd4;
        case (op)
            3'd0: begin r = {8'h00, b + 8'd1}; fo = {r[7:0] == 8'h00, 1'b0, b[3:0] == 4'hF, fin[0]};
                        cy = hl ? 5'd12 : 5'd4; end
            3'd1: begin r = {8'h00, b - 8'd1}; fo = {r[7:0] == 8'h00, 1'b1, b[3:0] == 4'h0, fin[0]};
                        cy = hl ? 5'd12 : 5'd4; end
            3'd2: begin s = {1'b0, wa} + {1'b0, wb}; hn = {1'b0, wa[11:8]} + {1'b0, wb[11:8]};
                        r = s[15:0]; fo = {fin[3], 1'b0, hn[4], s[16]}; cy = 5'd8; end
            3'd3: begin r = {8'h00, b[6:0], b[7]}; fo = {3'b000, b[7]}; end
            3'd4: begin r = {8'h00, b[0], b[7:1]}; fo = {3'b000, b[0]}; end
            3'd5: begin r = wb + 16'd1; cy = 5'd8; end
            3'd6: begin r = wb - 16'd1; cy = 5'd8; end
            default: ;
        endcase
    endfunction

    // Driver: apply one operation at the falling edge and queue its expectation.
    task automatic drive(input logic vld, input logic [2:0] op, input logic hl,
                         input logic [7:0] b, input logic [15:0] wa, input logic [15:0] wb,
                         input string tag);
        logic [15:0] r; logic [3:0] f; logic [4:0] cy;
        @(negedge clk);
        op_vld = vld; op_code = op; via_hl = hl; byte_in = b; word_a = wa; word_b = wb;
        model(op, hl, b, wa, wb, mdl_f, r, f, cy);
        if (vld) mdl_f = f;
        q_res.push_back(r); q_flg.push_back({mdl_f, 4'h0}); q_cyc.push_back(cy);
        q_chk.push_back(vld); q_tag.push_back(tag);
    endtask

    // Monitor: after each rising edge compare result, cost and updated flags.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_res.size() > 0) begin
                logic [15:0] er; logic [7:0] ef; logic [4:0] ec; bit ck; string tg;
                er = q_res.pop_front(); ef = q_flg.pop_front(); ec = q_cyc.pop_front();
                ck = q_chk.pop_front(); tg = q_tag.pop_front();
                checks++;
                if (flags_o !== ef || (ck && (res_o !== er || cycles_o !== ec))) begin
                    errors++;
                    $display("FAIL %s: res %h/%h flags %h/%h cycles %0d/%0d (actual/expected)",
                             tg, res_o, er, flags_o, ef, cycles_o, ec);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        checks++;                                   // R7 reset state
        if (flags_o !== 8'h00) begin
            errors++;
            $display("FAIL R7 reset flags %h expected 00", flags_o);
        end
        drive(1, 3'd0, 0, 8'hFF, 0, 0, "R1 inc wrap to zero");
        drive(1, 3'd0, 1, 8'h0F, 0, 0, "R1 R6 inc nibble carry via HL");
        drive(1, 3'd0, 0, 8'h41, 0, 0, "R1 inc plain");
        drive(1, 3'd1, 0, 8'h01, 0, 0, "R2 dec to zero");
        drive(1, 3'd1, 1, 8'h00, 0, 0, "R2 R6 dec borrow wrap via HL");
        drive(1, 3'd1, 0, 8'h10, 0, 0, "R2 dec nibble borrow");
        drive(1, 3'd3, 0, 8'h80, 0, 0, "R4 rotl carry out");
        drive(1, 3'd1, 0, 8'h37, 0, 0, "R2 dec keeps carry");
        drive(1, 3'd0, 0, 8'hFF, 0, 0, "R1 sets Z for add16 test");
        drive(1, 3'd2, 0, 8'h00, 16'hFFFF, 16'h0001, "R3 add wrap keeps Z, no H");
        drive(1, 3'd2, 0, 8'h00, 16'h0880, 16'h0880, "R3 add H from bits 11..8");
        drive(1, 3'd2, 0, 8'h00, 16'h00FF, 16'h0F01, "R3 low-byte carry not in H");
        drive(1, 3'd4, 0, 8'h01, 0, 0, "R4 rotr wrap bit 0");
        drive(1, 3'd3, 0, 8'h00, 0, 0, "R4 rotl zero result clears Z");
        drive(1, 3'd4, 0, 8'hA6, 0, 0, "R4 rotr no carry");
        drive(1, 3'd5, 0, 8'h00, 0, 16'hFFFF, "R5 R6 word inc wrap");
        drive(1, 3'd6, 0, 8'h00, 0, 16'h0000, "R5 word dec wrap");
        drive(1, 3'd1, 0, 8'h01, 0, 0, "R2 setup flags");
        drive(0, 3'd3, 0, 8'h80, 0, 0, "R8 idle rotate ignored");
        drive(1, 3'd7, 0, 8'h55, 16'h1234, 16'h4321, "R8 R6 reserved code");
        drive(0, 3'd0, 0, 8'hFF, 0, 0, "R8 idle inc ignored");
        @(negedge clk);
        op_vld = 1'b0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule